// File: doc/BRIEF.md
# Translation Cache Invalidation Controller

This block is the control side of a page translation cache inside a memory management unit. For every translation entry it stores a valid bit, a 32-bit tag word and a supervisor flag. The upper 20 bits of the tag word are the virtual page. The lower 12 bits are control bits that the block never interprets. Software reaches the block through a word-addressed register port. That port holds a command register, a system address register, two root pointer registers, fault status and fault address registers, a control register and eight block-window registers.

Writing a flush code to the command register invalidates translation entries in parallel. The flush selects entries by privilege level and, for the page variants, by virtual page. Writes to the window, root pointer, fault and control registers send a one-cycle global flush pulse to the processor side. A plain load port fills entries, and a combinational read port exposes any entry so that its state can be observed.

Top module: `xlat_inval_ctrl`

## Requirements
- R1: After reset every entry is invalid, every stored register reads as zero, and `err_o`, `flush_o`, `done_o` and `reg_rvalid_o` are low.
- R2: Writing a flush code to word 0x01 (0x24 user-page, 0x25 user-all, 0x26 supervisor-page, 0x27 supervisor-all; code bit 0 selects all pages, code bit 1 selects supervisor) clears the selected entries on the second clock edge after the write. `done_o` and `flush_o` are high together for exactly that one cycle.
- R3: A flush clears an entry only when the entry's supervisor flag equals bit 1 of the command code.
- R4: The page variants clear an entry only when tag bits 31:12 equal bits 31:12 of the system address register (word 0x05). The all-page variants skip this comparison.
- R5: A flush never touches an entry that is already invalid, and it never changes any entry's tag word or supervisor flag.
- R6: Writing window word 0x10+k (k = 0..7) stores the value and drives it on `blk_win_o[32k+31:32k]`. `flush_o` pulses in the cycle after the write only when the new value differs from the stored one.
- R7: A write to the fault status (0x03), fault address (0x04), system address (0x05), control (0x06), supervisor root (0x07) or user root (0x08) word stores the value and pulses `flush_o` for one cycle after the write.
- R8: Writing any other code to word 0x01, or reading word 0x01, sets the sticky `err_o` in the cycle after. Neither case starts a flush, changes an entry or raises `done_o`.
- R9: Reading the status word 0x02 returns the error flag in bit 0 and clears `err_o`.
- R10: A read returns `reg_rdata_o` together with `reg_rvalid_o` one cycle after `reg_re_i`. Word 0x00 reads as the identity parameter. Writes to 0x00 and 0x02 have no effect.
- R11: The load port writes the tag word, supervisor flag and valid bit of entry `ent_widx_i` on the next clock edge. The read port shows entry `ent_ridx_i` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 5 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, one cycle after the read |
| reg_rvalid_o | output | 1 | Read data valid |
| ent_we_i | input | 1 | Entry load strobe |
| ent_widx_i | input | IDX_W | Entry load index |
| ent_wtag_i | input | 32 | Entry load tag word |
| ent_wsup_i | input | 1 | Entry load supervisor flag |
| ent_wvalid_i | input | 1 | Entry load valid bit |
| ent_ridx_i | input | IDX_W | Entry observe index |
| ent_rtag_o | output | 32 | Observed tag word |
| ent_rsup_o | output | 1 | Observed supervisor flag |
| ent_rvalid_o | output | 1 | Observed valid bit |
| blk_win_o | output | 8*32 | Block-window values, slot k at bits 32k+31:32k |
| flush_o | output | 1 | Global translation flush pulse |
| done_o | output | 1 | Command completion strobe |
| err_o | output | 1 | Sticky command error flag |

## Verification
The hardest case to reach is a page flush where the four selection conditions disagree. Some entries match on page but carry the wrong privilege, some are already invalid but otherwise match, and some differ from the system address only in the low 12 bits. The bench loads entries with patterns that vary page, privilege and valid bit independently of one another. It places control garbage in the low bits of both the tag words and the system address, then checks every entry against a model after each command. A bad command is issued over a populated cache to show that nothing moves.

// File: rtl/xlat_inval_pkg.sv
package xlat_inval_pkg;
  localparam int REG_AW = 5;
  localparam int DW     = 32;

  localparam logic [REG_AW-1:0] A_IDENT = 5'h00;
  localparam logic [REG_AW-1:0] A_CMD   = 5'h01;
  localparam logic [REG_AW-1:0] A_STAT  = 5'h02;
  localparam logic [REG_AW-1:0] A_FSTAT = 5'h03;
  localparam logic [REG_AW-1:0] A_UROOT = 5'h08;
  localparam logic [REG_AW-1:0] A_WIN0  = 5'h10;

  localparam logic [7:0] CMD_USR_PAGE = 8'h24;
  localparam logic [7:0] CMD_USR_ALL  = 8'h25;
  localparam logic [7:0] CMD_SUP_PAGE = 8'h26;
  localparam logic [7:0] CMD_SUP_ALL  = 8'h27;

  typedef struct packed {
    logic sup;
    logic all;
  } flush_sel_t;

  function automatic logic is_flush_cmd(input logic [7:0] code);
    return code[7:2] == 6'b001001;
  endfunction
endpackage

// File: rtl/xlat_cmd_unit.sv
module xlat_cmd_unit
  import xlat_inval_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_we_i,
  input  logic [7:0] code_i,
  output logic       exec_o,
  output flush_sel_t sel_o,
  output logic       done_o,
  output logic       bad_o
);
  logic [7:0] code_q;
  logic       exec_q, done_q;

  assign bad_o = cmd_we_i & ~is_flush_cmd(code_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      exec_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (cmd_we_i) code_q <= code_i;
      exec_q <= cmd_we_i & is_flush_cmd(code_i);
      done_q <= exec_q;
    end
  end

  assign exec_o    = exec_q;
  assign sel_o.sup = code_q[1];
  assign sel_o.all = code_q[0];
  assign done_o    = done_q;
endmodule

// File: rtl/xlat_entry_array.sv
module xlat_entry_array
  import xlat_inval_pkg::*;
#(
  parameter int N_ENT = 56,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_we_i,
  input  logic [IDX_W-1:0] ld_idx_i,
  input  logic [DW-1:0]    ld_tag_i,
  input  logic             ld_sup_i,
  input  logic             ld_valid_i,
  input  logic             exec_i,
  input  flush_sel_t       sel_i,
  input  logic [19:0]      sar_page_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [DW-1:0]    rd_tag_o,
  output logic             rd_sup_o,
  output logic             rd_valid_o
);
  logic [N_ENT-1:0] valid_q, sup_q, hit;
  logic [DW-1:0]    tag_q [N_ENT];

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    logic ld_sel;
    assign ld_sel = ld_we_i && (ld_idx_i == IDX_W'(i));
    // candidate: valid, privilege equal, page equal unless all-pages
    assign hit[i] = valid_q[i] && (sup_q[i] == sel_i.sup) &&
                    (sel_i.all || (tag_q[i][31:12] == sar_page_i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[i] <= 1'b0;
        sup_q[i]   <= 1'b0;
        tag_q[i]   <= '0;
      end else begin
        if (ld_sel) begin
          valid_q[i] <= ld_valid_i;
          sup_q[i]   <= ld_sup_i;
          tag_q[i]   <= ld_tag_i;
        end else if (exec_i && hit[i]) begin
          valid_q[i] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    rd_tag_o   = '0;
    rd_sup_o   = 1'b0;
    rd_valid_o = 1'b0;
    for (int i = 0; i < N_ENT; i++) begin
      if (rd_idx_i == IDX_W'(i)) begin
        rd_tag_o   = tag_q[i];
        rd_sup_o   = sup_q[i];
        rd_valid_o = valid_q[i];
      end
    end
  end
endmodule

// File: rtl/xlat_regs.sv
module xlat_regs
  import xlat_inval_pkg::*;
#(
  parameter logic [DW-1:0] ID_VALUE = 32'h0C0D_0200,
  parameter int N_WIN = 8,
  localparam int N_SIDE = 6,
  localparam int SIDE_IW = $clog2(N_SIDE),
  localparam int WIN_IW = $clog2(N_WIN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              bad_cmd_i,
  output logic              cmd_we_o,
  output logic [DW-1:0]     rdata_o,
  output logic              rvalid_o,
  output logic [19:0]       sar_page_o,
  output logic              flush_o,
  output logic              err_o,
  output logic [N_WIN*DW-1:0] win_o
);
  localparam logic [REG_AW-1:0] A_SADDR_OFF = 5'd2; // sys addr within side block

  logic [DW-1:0] side_q [N_SIDE];
  logic [DW-1:0] win_q  [N_WIN];
  logic [DW-1:0] rdata_q, rd_mux;
  logic          rvalid_q, flush_q, err_q;
  logic          side_hit, win_hit, win_chg, cmd_rd, stat_rd;
  logic [REG_AW-1:0] side_off, win_off;
  logic [SIDE_IW-1:0] side_idx;
  logic [WIN_IW-1:0]  win_idx;

  assign side_off = addr_i - A_FSTAT;
  assign win_off  = addr_i - A_WIN0;
  assign side_idx = side_off[SIDE_IW-1:0];
  assign win_idx  = win_off[WIN_IW-1:0];
  assign side_hit = (addr_i >= A_FSTAT) && (addr_i <= A_UROOT);
  assign win_hit  = (addr_i >= A_WIN0) && (win_off < REG_AW'(N_WIN));
  assign win_chg  = win_q[win_idx] != wdata_i;
  assign cmd_we_o = we_i && (addr_i == A_CMD);
  assign cmd_rd   = re_i && (addr_i == A_CMD);
  assign stat_rd  = re_i && (addr_i == A_STAT);

  for (genvar s = 0; s < N_SIDE; s++) begin : g_side
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  side_q[s] <= '0;
      else if (we_i && side_hit && side_idx == SIDE_IW'(s)) side_q[s] <= wdata_i;
    end
  end

  for (genvar w = 0; w < N_WIN; w++) begin : g_win
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 win_q[w] <= '0;
      else if (we_i && win_hit && win_idx == WIN_IW'(w)) win_q[w] <= wdata_i;
    end
    assign win_o[w*DW +: DW] = win_q[w];
  end

  always_comb begin
    rd_mux = '0;
    if (addr_i == A_IDENT)     rd_mux = ID_VALUE;
    else if (addr_i == A_STAT) rd_mux = {{(DW-1){1'b0}}, err_q};
    else if (side_hit)         rd_mux = side_q[side_idx];
    else if (win_hit)          rd_mux = win_q[win_idx];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      flush_q  <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      rvalid_q <= re_i;
      if (re_i) rdata_q <= rd_mux;
      flush_q  <= we_i && (side_hit || (win_hit && win_chg));
      // set wins over clear
      err_q    <= bad_cmd_i || cmd_rd || (err_q && !stat_rd);
    end
  end

  assign rdata_o    = rdata_q;
  assign rvalid_o   = rvalid_q;
  assign flush_o    = flush_q;
  assign err_o      = err_q;
  assign sar_page_o = side_q[A_SADDR_OFF][31:12];
endmodule

// File: rtl/xlat_inval_ctrl.sv
module xlat_inval_ctrl
  import xlat_inval_pkg::*;
#(
  parameter int N_ENT = 56,
  parameter int N_WIN = 8,
  parameter logic [31:0] ID_VALUE = 32'h0C0D_0200,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              reg_rvalid_o,
  input  logic              ent_we_i,
  input  logic [IDX_W-1:0]  ent_widx_i,
  input  logic [31:0]       ent_wtag_i,
  input  logic              ent_wsup_i,
  input  logic              ent_wvalid_i,
  input  logic [IDX_W-1:0]  ent_ridx_i,
  output logic [31:0]       ent_rtag_o,
  output logic              ent_rsup_o,
  output logic              ent_rvalid_o,
  output logic [N_WIN*32-1:0] blk_win_o,
  output logic              flush_o,
  output logic              done_o,
  output logic              err_o
);
  logic       cmd_we, bad_cmd, exec, reg_flush;
  flush_sel_t sel;
  logic [19:0] sar_page;

  xlat_regs #(.ID_VALUE(ID_VALUE), .N_WIN(N_WIN)) i_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .re_i(reg_re_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .bad_cmd_i(bad_cmd), .cmd_we_o(cmd_we),
    .rdata_o(reg_rdata_o), .rvalid_o(reg_rvalid_o),
    .sar_page_o(sar_page), .flush_o(reg_flush), .err_o(err_o), .win_o(blk_win_o)
  );

  xlat_cmd_unit i_cmd (
    .clk_i, .rst_ni,
    .cmd_we_i(cmd_we), .code_i(reg_wdata_i[7:0]),
    .exec_o(exec), .sel_o(sel), .done_o(done_o), .bad_o(bad_cmd)
  );

  xlat_entry_array #(.N_ENT(N_ENT)) i_ents (
    .clk_i, .rst_ni,
    .ld_we_i(ent_we_i), .ld_idx_i(ent_widx_i), .ld_tag_i(ent_wtag_i),
    .ld_sup_i(ent_wsup_i), .ld_valid_i(ent_wvalid_i),
    .exec_i(exec), .sel_i(sel), .sar_page_i(sar_page),
    .rd_idx_i(ent_ridx_i), .rd_tag_o(ent_rtag_o), .rd_sup_o(ent_rsup_o),
    .rd_valid_o(ent_rvalid_o)
  );

  assign flush_o = reg_flush | done_o;
endmodule

// File: rtl/xlat_inval_ctrl_chk.sv
module xlat_inval_ctrl_chk
  import xlat_inval_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic              reg_re_i,
  input logic [REG_AW-1:0] reg_addr_i,
  input logic [31:0]       reg_wdata_i,
  input logic              reg_rvalid_o,
  input logic              ent_we_i,
  input logic [IDX_W-1:0]  ent_ridx_i,
  input logic [31:0]       ent_rtag_o,
  input logic              ent_rvalid_o,
  input logic              flush_o,
  input logic              done_o,
  input logic              err_o
);
  logic cmd_wr, good_cmd, bad_cmd, side_wr, stat_rd;
  assign cmd_wr   = reg_we_i && (reg_addr_i == A_CMD);
  assign good_cmd = cmd_wr && is_flush_cmd(reg_wdata_i[7:0]);
  assign bad_cmd  = cmd_wr && !is_flush_cmd(reg_wdata_i[7:0]);
  assign side_wr  = reg_we_i && (reg_addr_i >= A_FSTAT) && (reg_addr_i <= A_UROOT);
  assign stat_rd  = reg_re_i && (reg_addr_i == A_STAT);

  AST_CMD_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    good_cmd |-> ##2 done_o); // R2
  AST_DONE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(good_cmd, 2)); // R2
  AST_SIDE_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    side_wr |=> flush_o); // R7
  AST_BAD_CMD_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_cmd |=> err_o); // R8
  AST_ERR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd && !bad_cmd) |=> !err_o); // R9
  AST_RVALID_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_i |=> reg_rvalid_o); // R10
  AST_RVALID_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_re_i |=> !reg_rvalid_o); // R10
  AST_NO_REVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ent_we_i && !ent_rvalid_o) |=> (($past(ent_ridx_i) != ent_ridx_i) || !ent_rvalid_o)); // R5
  AST_TAG_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ent_we_i |=> (($past(ent_ridx_i) != ent_ridx_i) || $stable(ent_rtag_o))); // R5
endmodule

bind xlat_inval_ctrl xlat_inval_ctrl_chk #(.IDX_W(IDX_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_re_i(reg_re_i),
  .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rvalid_o(reg_rvalid_o),
  .ent_we_i(ent_we_i), .ent_ridx_i(ent_ridx_i), .ent_rtag_o(ent_rtag_o),
  .ent_rvalid_o(ent_rvalid_o), .flush_o(flush_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/test_xlat_inval_ctrl.sv
module test_xlat_inval_ctrl;
  localparam int N = 56;
  localparam int IW = $clog2(N);
  localparam logic [31:0] ID = 32'h0C0D_0200;

  logic clk_i = 0, rst_ni = 0;
  logic reg_we_i = 0, reg_re_i = 0;
  logic [4:0] reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o;
  logic reg_rvalid_o;
  logic ent_we_i = 0, ent_wsup_i = 0, ent_wvalid_i = 0;
  logic [IW-1:0] ent_widx_i = '0, ent_ridx_i = '0;
  logic [31:0] ent_wtag_i = '0, ent_rtag_o;
  logic ent_rsup_o, ent_rvalid_o;
  logic [255:0] blk_win_o;
  logic flush_o, done_o, err_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic        m_valid [N];
  logic        m_sup   [N];
  logic [31:0] m_tag   [N];

  always #4 clk_i = ~clk_i;

  xlat_inval_ctrl i_xlat_inval_ctrl (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic reg_wr(input logic [4:0] a, input logic [31:0] d,
                        output logic f0, output logic d0, output logic f1, output logic d1);
    @(negedge clk_i); reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i); reg_we_i = 0; f0 = flush_o; d0 = done_o;
    @(negedge clk_i); f1 = flush_o; d1 = done_o;
  endtask

  task automatic reg_rd(input logic [4:0] a, output logic [31:0] d, output logic v);
    @(negedge clk_i); reg_re_i = 1; reg_addr_i = a;
    @(negedge clk_i); reg_re_i = 0; d = reg_rdata_o; v = reg_rvalid_o;
  endtask

  task automatic ent_ld(input int i, input logic [31:0] t, input logic s, input logic v);
    @(negedge clk_i); ent_we_i = 1; ent_widx_i = IW'(i); ent_wtag_i = t; ent_wsup_i = s; ent_wvalid_i = v;
    @(negedge clk_i); ent_we_i = 0;
    m_valid[i] = v; m_sup[i] = s; m_tag[i] = t;
  endtask

  task automatic check_ents(input string req);
    for (int i = 0; i < N; i++) begin
      ent_ridx_i = IW'(i); #1;
      chk({ent_rvalid_o, ent_rsup_o} == {m_valid[i], m_sup[i]} && ent_rtag_o == m_tag[i],
          req, {ent_rvalid_o, ent_rsup_o, ent_rtag_o[29:0]}, {m_valid[i], m_sup[i], m_tag[i][29:0]});
    end
  endtask

  // page in bits 31:12 cycles over 4 values, garbage in low bits
  task automatic fill(input int seed);
    for (int i = 0; i < N; i++)
      ent_ld(i, {20'h1000 + 20'((i + seed) % 4), 12'(i * 37 + 5)}, 1'((i / 2 + seed) % 2),
             1'(((i + seed) % 7) != 0));
  endtask

  function automatic void model_flush(input logic [7:0] c, input logic [31:0] sar);
    for (int i = 0; i < N; i++)
      if (m_valid[i] && m_sup[i] == c[1] && (c[0] || m_tag[i][31:12] == sar[31:12]))
        m_valid[i] = 1'b0;
  endfunction

  task automatic run_cmd(input logic [7:0] c, input logic [31:0] sar, input string req);
    logic f0, d0, f1, d1, f2, d2;
    reg_wr(5'h01, {24'h0, c}, f0, d0, f1, d1);
    f2 = flush_o; d2 = done_o;
    @(negedge clk_i); f2 = flush_o; d2 = done_o;
    chk(!d0 && d1 && !d2, "R2 done strobe timing", {d0, d1, d2}, 3'b010);
    chk(!f0 && f1 && !f2, "R2 flush with done", {f0, f1, f2}, 3'b010);
    model_flush(c, sar);
    check_ents(req);
  endtask

  task automatic t_reset();
    logic [31:0] d; logic v;
    chk(!err_o && !flush_o && !done_o && !reg_rvalid_o, "R1 outputs low after reset",
        {err_o, flush_o, done_o, reg_rvalid_o}, 0);
    for (int i = 0; i < N; i++) begin m_valid[i] = 0; m_sup[i] = 0; m_tag[i] = 0; end
    check_ents("R1 entries cleared");
    reg_rd(5'h05, d, v); chk(d == 0 && v, "R1 sys addr zero", d, 0);
    chk(blk_win_o == '0, "R1 windows zero", blk_win_o[31:0], 0);
    reg_rd(5'h00, d, v); chk(d == ID && v, "R10 ident read", d, ID);
    @(negedge clk_i); chk(!reg_rvalid_o, "R10 rvalid single cycle", reg_rvalid_o, 0);
  endtask

  task automatic t_load();
    fill(0);
    check_ents("R11 entry load");
  endtask

  task automatic t_page_flushes();
    logic f0, d0, f1, d1;
    logic [31:0] sar = {20'h1002, 12'hFFF};
    reg_wr(5'h05, sar, f0, d0, f1, d1);
    chk(f0 && !f1, "R7 sys addr write flush", {f0, f1}, 2'b10);
    run_cmd(8'h26, sar, "R4 supervisor page flush R3 R5");
    sar = {20'h1001, 12'h000};
    reg_wr(5'h05, sar, f0, d0, f1, d1);
    run_cmd(8'h24, sar, "R4 user page flush R3");
  endtask

  task automatic t_all_flushes();
    run_cmd(8'h25, 32'h1001_0000, "R3 user all flush");
    fill(3);
    run_cmd(8'h27, 32'h0, "R3 supervisor all flush");
    run_cmd(8'h25, 32'h0, "R5 user all over partly invalid");
  endtask

  task automatic t_bad_cmd();
    logic f0, d0, f1, d1; logic [31:0] d; logic v;
    fill(1);
    reg_wr(5'h01, 32'h0000_0030, f0, d0, f1, d1);
    chk(!d0 && !d1 && !f0 && !f1, "R8 bad command no done", {d0, d1, f0, f1}, 0);
    chk(err_o, "R8 bad command sets error", err_o, 1);
    check_ents("R8 cache untouched");
    reg_rd(5'h02, d, v); chk(d == 1, "R9 status shows error", d, 1);
    chk(!err_o, "R9 status read clears", err_o, 0);
    reg_rd(5'h02, d, v); chk(d == 0, "R9 status reads clear", d, 0);
    reg_rd(5'h01, d, v);
    chk(err_o, "R8 command read sets error", err_o, 1);
    @(negedge clk_i); chk(err_o, "R8 error sticky", err_o, 1);
    check_ents("R8 cache untouched after read");
    reg_rd(5'h02, d, v); chk(d == 1 && !err_o, "R9 clear after command read", {d[0], err_o}, 2'b10);
  endtask

  task automatic t_windows();
    logic f0, d0, f1, d1; logic [31:0] d; logic v;
    reg_wr(5'h13, 32'hA5A5_0003, f0, d0, f1, d1);
    chk(f0 && !f1, "R6 window change flush", {f0, f1}, 2'b10);
    chk(blk_win_o[127:96] == 32'hA5A5_0003, "R6 window mirror slot 3", blk_win_o[127:96], 32'hA5A5_0003);
    reg_rd(5'h13, d, v); chk(d == 32'hA5A5_0003, "R6 window readback", d, 32'hA5A5_0003);
    reg_wr(5'h13, 32'hA5A5_0003, f0, d0, f1, d1);
    chk(!f0 && !f1, "R6 same value no flush", {f0, f1}, 0);
    reg_wr(5'h17, 32'h0000_0000, f0, d0, f1, d1);
    chk(!f0, "R6 zero over zero no flush", f0, 0);
    reg_wr(5'h17, 32'h7777_0001, f0, d0, f1, d1);
    chk(f0 && blk_win_o[255:224] == 32'h7777_0001, "R6 window slot 7", blk_win_o[255:224], 32'h7777_0001);
    chk(blk_win_o[31:0] == 0, "R6 other slot unchanged", blk_win_o[31:0], 0);
  endtask

  task automatic t_side_regs();
    logic f0, d0, f1, d1; logic [31:0] d; logic v;
    for (int a = 3; a <= 8; a++) begin
      reg_wr(5'(a), 32'h5000_0000 + 32'(a), f0, d0, f1, d1);
      chk(f0 && !f1 && !d1, "R7 side register flush pulse", {f0, f1, d1}, 3'b100);
      reg_rd(5'(a), d, v);
      chk(d == 32'h5000_0000 + 32'(a) && v, "R7 side register stored", d, 32'h5000_0000 + 32'(a));
    end
    reg_wr(5'h00, 32'hDEAD_BEEF, f0, d0, f1, d1);
    reg_rd(5'h00, d, v); chk(d == ID && !f0, "R10 ident write ignored", d, ID);
    reg_wr(5'h02, 32'h1, f0, d0, f1, d1);
    chk(!err_o, "R10 status write ignored", err_o, 0);
  endtask

  initial begin
    #(8 * 150000);
    chk(0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_load();
    t_page_flushes();
    t_all_flushes();
    t_bad_cmd();
    t_windows();
    t_side_regs();
    repeat (2) @(negedge clk_i);
    summary();
  end
endmodule